// File: doc/BRIEF.md
# DMA Channel Command Sequencer

This block is the control core of a single DMA channel. Software writes single-cycle command strobes (start, pause, abort), selects either a one-shot direct transfer or a descriptor-chained run, and chooses whether FIFO contents are kept or thrown away after a failed source read. The sequencer turns these commands into a request/response handshake with an external transfer engine. It asks for a descriptor fetch, starts each transfer, and reacts to the engine's completion, error and end-of-chain replies.

It also drives one-cycle pulses that invalidate or drain the channel FIFO and stop the engine at once. It keeps four status bits: busy, done, error and paused. The bus masters, the FIFO storage, the address and count registers and descriptor parsing all live outside this block.

Top module: `dma_cmd_seq`

## Requirements
- R1: With `mode_direct`=1, an accepted start gives exactly one `xfer_start` pulse in the cycle after the command and sets busy. A following `xfer_done` clears busy, sets done and leaves err at 0.
- R2: With `mode_direct`=0, an accepted start pulses `desc_fetch` with `desc_first`=1, which means the first descriptor comes from the next-descriptor address. Each `desc_done` pulses `xfer_start`. Each `xfer_done` that is not on the descriptor marked `desc_last` pulses `desc_fetch` with `desc_first`=0. The `xfer_done` on the last descriptor completes the run the same way as R1.
- R3: A pause accepted in chained mode keeps busy=1 until the current transfer's `xfer_done`. After that, no fetch is issued, busy falls, and `paused` rises in that cycle and not before.
- R4: A start issued while paused resumes the chain with `desc_fetch` and `desc_first`=0, and it leaves done and err at 0.
- R5: An abort in a fetch, transfer or paused state gives one-cycle `eng_halt` and `fifo_inval` pulses in the next cycle. In that same cycle busy and paused read 0 and done and err read 1.
- R6: An abort overrides a pending pause, an effective pause, and a start written in the same cycle.
- R7: A start after an abort begins a fresh operation. In chained mode it fetches with `desc_first`=1.
- R8: An `xfer_err` in a transfer ends the operation with done=1 and err=1. The FIFO action depends on `flush_en`: with `flush_en`=1 there is a `fifo_drain` pulse and no `fifo_inval`; with `flush_en`=0 there is a `fifo_inval` pulse. When `xfer_err` and `xfer_done` arrive in the same cycle, `xfer_err` takes precedence.
- R9: A start written while busy has no effect: it produces no extra `xfer_start` or `desc_fetch`.
- R10: An accepted start from the idle or finished state clears done and err in the next cycle.
- R11: After reset, and after a reset in the middle of an operation, every output reads 0.
- R12: A pause in direct mode has no effect: the transfer completes to done and paused stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_go | input | 1 | Start/resume strobe |
| cmd_pause | input | 1 | Pause strobe |
| cmd_abort | input | 1 | Abort strobe |
| mode_direct | input | 1 | 1 = single direct transfer, 0 = descriptor chain |
| flush_en | input | 1 | Drain FIFO on a failed read instead of discarding |
| desc_done | input | 1 | Descriptor fetch finished |
| desc_last | input | 1 | Fetched descriptor is the end of the chain (valid with desc_done) |
| xfer_done | input | 1 | Transfer finished |
| xfer_err | input | 1 | Transfer ended by a source-read exception |
| xfer_start | output | 1 | Start-transfer pulse |
| desc_fetch | output | 1 | Fetch-descriptor pulse |
| desc_first | output | 1 | Fetch uses the next-descriptor address (valid with desc_fetch) |
| eng_halt | output | 1 | Stop-engine pulse |
| fifo_inval | output | 1 | Invalidate-FIFO pulse |
| fifo_drain | output | 1 | Drain-FIFO pulse |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished |
| err | output | 1 | Operation finished with error or abort |
| paused | output | 1 | Chain stopped at a descriptor boundary |

## Verification
Two pairs of functions can land in one cycle: a pause with an abort, and a start with an abort. A further case is a pause that stays pending until a transfer completes. The stimulus table drives pause and abort together during a fetch, and start and abort together while paused. It then checks that the cycle after shows the abort outcome (halt, invalidate, done and error) rather than a pause or a resumed fetch. A separate row drives `xfer_err` together with `xfer_done` and expects the error result.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FETCH  = 3'd1,
        ST_XFER   = 3'd2,
        ST_PAUSED = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic go;
        logic pause;
        logic abort;
    } cmd_t;

    typedef struct packed {
        logic desc_done;
        logic desc_last;
        logic xfer_done;
        logic xfer_err;
    } eng_rsp_t;

    typedef struct packed {
        logic ok;
        logic exc;
        logic abort;
    } fin_ev_t;

    function automatic logic st_active(seq_state_e s);
        return (s == ST_FETCH) || (s == ST_XFER);
    endfunction

    function automatic logic st_can_start(seq_state_e s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/dma_cmd_arb.sv
module dma_cmd_arb
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       cmd_raw,
    input  seq_state_e st,
    input  logic       op_direct,
    output cmd_t       cmd_take
);

    logic abort_ok;
    logic go_ok;
    logic pause_ok;

    always_comb begin
        abort_ok = cmd_raw.abort && (st_active(st) || st == ST_PAUSED);
        go_ok    = cmd_raw.go && !abort_ok && (st_can_start(st) || st == ST_PAUSED);
        pause_ok = cmd_raw.pause && !abort_ok && st_active(st) && !op_direct;
        cmd_take = '{go: go_ok, pause: pause_ok, abort: abort_ok};
    end

    // R6: an effective abort suppresses every other command in its cycle
    p_abort_wins_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_raw.abort && (st_active(st) || st == ST_PAUSED)) |-> (!cmd_take.go && !cmd_take.pause));

    // R9: start while busy is dropped
    p_go_busy_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        st_active(st) |-> !cmd_take.go);

endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  cmd_t       take,
    input  logic       mode_direct,
    input  eng_rsp_t   rsp,
    output seq_state_e st,
    output logic       op_direct,
    output logic       xfer_start,
    output logic       desc_fetch,
    output logic       desc_first,
    output fin_ev_t    ev
);

    seq_state_e st_n;
    logic       last_q;
    logic       pause_pend;
    logic       pause_eff;
    logic       fresh_start;

    assign pause_eff   = pause_pend || take.pause;
    assign fresh_start = take.go && st_can_start(st);

    always_comb begin
        st_n = st;
        ev   = '0;
        if (take.abort) begin
            st_n     = ST_DONE;
            ev.abort = 1'b1;
        end else begin
            unique case (st)
                ST_IDLE, ST_DONE: begin
                    if (take.go) st_n = mode_direct ? ST_XFER : ST_FETCH;
                end
                ST_PAUSED: begin
                    if (take.go) st_n = ST_FETCH;
                end
                ST_FETCH: begin
                    if (rsp.desc_done) st_n = ST_XFER;
                end
                ST_XFER: begin
                    if (rsp.xfer_err) begin
                        st_n   = ST_DONE;
                        ev.exc = 1'b1;
                    end else if (rsp.xfer_done) begin
                        if (op_direct || last_q) begin
                            st_n  = ST_DONE;
                            ev.ok = 1'b1;
                        end else if (pause_eff) begin
                            st_n = ST_PAUSED;
                        end else begin
                            st_n = ST_FETCH;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            op_direct  <= 1'b0;
            last_q     <= 1'b0;
            pause_pend <= 1'b0;
            xfer_start <= 1'b0;
            desc_fetch <= 1'b0;
            desc_first <= 1'b0;
        end else begin
            st         <= st_n;
            xfer_start <= (st_n == ST_XFER) && (st != ST_XFER);
            desc_fetch <= (st_n == ST_FETCH) && (st != ST_FETCH);
            desc_first <= (st_n == ST_FETCH) && st_can_start(st);
            if (fresh_start && !take.abort)
                op_direct <= mode_direct;
            if (fresh_start)
                last_q <= 1'b0;
            else if (st == ST_FETCH && rsp.desc_done)
                last_q <= rsp.desc_last;
            pause_pend <= st_active(st_n) ? pause_eff : 1'b0;
        end
    end

    // R2: a fresh chained start fetches from the next-descriptor address
    p_first_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (fresh_start && !mode_direct) |=> (desc_fetch && desc_first));

    // R4: resuming a paused chain does not restart it
    p_resume_next_r4: assert property (@(posedge clk) disable iff (rst)
        (st == ST_PAUSED && take.go) |=> (desc_fetch && !desc_first));

    // R3: the paused state is only entered from a finished transfer
    p_pause_at_boundary_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(st == ST_PAUSED) |-> $past(st == ST_XFER && rsp.xfer_done));

    // R12: a direct operation never pauses
    p_direct_no_pause_r12: assert property (@(posedge clk) disable iff (rst)
        (op_direct && st == ST_XFER) |=> (st != ST_PAUSED));

endmodule

// File: rtl/dma_fifo_ctl.sv
module dma_fifo_ctl
    import dma_seq_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  fin_ev_t ev,
    input  logic    flush_en,
    output logic    fifo_inval,
    output logic    fifo_drain,
    output logic    eng_halt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            fifo_inval <= 1'b0;
            fifo_drain <= 1'b0;
            eng_halt   <= 1'b0;
        end else begin
            fifo_inval <= ev.abort || (ev.exc && !flush_en);
            fifo_drain <= ev.exc && flush_en && !ev.abort;
            eng_halt   <= ev.abort;
        end
    end

    // R5: abort stops the engine and invalidates the FIFO in the next cycle
    p_abort_purge_r5: assert property (@(posedge clk) disable iff (rst)
        ev.abort |=> (eng_halt && fifo_inval && !fifo_drain));

    // R8: failed read with flush enabled drains rather than discards
    p_exc_drain_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.exc && flush_en) |=> (fifo_drain && !fifo_inval));

    // R8: failed read with flush disabled discards
    p_exc_discard_r8: assert property (@(posedge clk) disable iff (rst)
        (ev.exc && !flush_en) |=> (fifo_inval && !fifo_drain));

endmodule

// File: rtl/dma_status.sv
module dma_status
    import dma_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  seq_state_e st,
    input  cmd_t       take,
    input  fin_ev_t    ev,
    output logic       busy,
    output logic       paused,
    output logic       done,
    output logic       err
);

    assign busy   = st_active(st);
    assign paused = (st == ST_PAUSED);

    always_ff @(posedge clk) begin
        if (rst) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else if (ev.abort || ev.exc) begin
            done <= 1'b1;
            err  <= 1'b1;
        end else if (ev.ok) begin
            done <= 1'b1;
            err  <= 1'b0;
        end else if (take.go) begin
            done <= 1'b0;
            err  <= 1'b0;
        end
    end

    // R5: abort leaves the channel finished, failed and neither busy nor paused
    p_abort_status_r5: assert property (@(posedge clk) disable iff (rst)
        ev.abort |=> (done && err && !busy && !paused));

    // R1: normal completion is clean
    p_ok_status_r1: assert property (@(posedge clk) disable iff (rst)
        ev.ok |=> (done && !err && !busy));

    // R10: a start clears the previous result
    p_start_clears_r10: assert property (@(posedge clk) disable iff (rst)
        take.go |=> (!done && !err));

endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
    import dma_seq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cmd_go,
    input  logic cmd_pause,
    input  logic cmd_abort,
    input  logic mode_direct,
    input  logic flush_en,
    input  logic desc_done,
    input  logic desc_last,
    input  logic xfer_done,
    input  logic xfer_err,
    output logic xfer_start,
    output logic desc_fetch,
    output logic desc_first,
    output logic eng_halt,
    output logic fifo_inval,
    output logic fifo_drain,
    output logic busy,
    output logic done,
    output logic err,
    output logic paused
);

    cmd_t       cmd_raw;
    cmd_t       cmd_take;
    eng_rsp_t   rsp;
    fin_ev_t    ev;
    seq_state_e st;
    logic       op_direct;

    assign cmd_raw = '{go: cmd_go, pause: cmd_pause, abort: cmd_abort};
    assign rsp     = '{desc_done: desc_done, desc_last: desc_last,
                       xfer_done: xfer_done, xfer_err: xfer_err};

    dma_cmd_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .cmd_raw   (cmd_raw),
        .st        (st),
        .op_direct (op_direct),
        .cmd_take  (cmd_take)
    );

    dma_seq_fsm u_fsm (
        .clk         (clk),
        .rst         (rst),
        .take        (cmd_take),
        .mode_direct (mode_direct),
        .rsp         (rsp),
        .st          (st),
        .op_direct   (op_direct),
        .xfer_start  (xfer_start),
        .desc_fetch  (desc_fetch),
        .desc_first  (desc_first),
        .ev          (ev)
    );

    dma_fifo_ctl u_fifo (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .flush_en   (flush_en),
        .fifo_inval (fifo_inval),
        .fifo_drain (fifo_drain),
        .eng_halt   (eng_halt)
    );

    dma_status u_stat (
        .clk    (clk),
        .rst    (rst),
        .st     (st),
        .take   (cmd_take),
        .ev     (ev),
        .busy   (busy),
        .paused (paused),
        .done   (done),
        .err    (err)
    );

endmodule

// File: tb/dma_cmd_seq_bench.sv
module dma_cmd_seq_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_go = 0, cmd_pause = 0, cmd_abort = 0, mode_direct = 0, flush_en = 0;
    logic desc_done = 0, desc_last = 0, xfer_done = 0, xfer_err = 0;
    logic xfer_start, desc_fetch, desc_first, eng_halt, fifo_inval, fifo_drain;
    logic busy, done, err, paused;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    dma_cmd_seq u_dma_cmd_seq (
        .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_pause(cmd_pause),
        .cmd_abort(cmd_abort), .mode_direct(mode_direct), .flush_en(flush_en),
        .desc_done(desc_done), .desc_last(desc_last), .xfer_done(xfer_done),
        .xfer_err(xfer_err), .xfer_start(xfer_start), .desc_fetch(desc_fetch),
        .desc_first(desc_first), .eng_halt(eng_halt), .fifo_inval(fifo_inval),
        .fifo_drain(fifo_drain), .busy(busy), .done(done), .err(err), .paused(paused)
    );

    // fields: req[22:19], inputs[18:10] = go pause abort direct flush ddone dlast xdone xerr,
    // expected[9:0] = busy done err paused xstart dfetch dfirst inval drain halt
    localparam int NV = 32;
    localparam logic [22:0] VEC [NV] = '{
        {4'd1,  9'b100100000, 10'b1000100000},  // R1 direct start
        {4'd1,  9'b000100000, 10'b1000000000},  // R1 running
        {4'd9,  9'b100100000, 10'b1000000000},  // R9 start while busy
        {4'd1,  9'b000100010, 10'b0100000000},  // R1 clean finish
        {4'd10, 9'b100000000, 10'b1000011000},  // R10 R2 chained start
        {4'd2,  9'b000001000, 10'b1000100000},  // R2 descriptor in
        {4'd3,  9'b010000000, 10'b1000000000},  // R3 pause pending
        {4'd3,  9'b000000010, 10'b0001000000},  // R3 reaches pause
        {4'd3,  9'b000000000, 10'b0001000000},  // R3 stays paused
        {4'd4,  9'b100000000, 10'b1000010000},  // R4 resume
        {4'd2,  9'b000001100, 10'b1000100000},  // R2 last descriptor
        {4'd2,  9'b000000010, 10'b0100000000},  // R2 chain end
        {4'd2,  9'b100000000, 10'b1000011000},  // R2 new chain
        {4'd2,  9'b000001000, 10'b1000100000},  // R2
        {4'd8,  9'b000010001, 10'b0110000010},  // R8 flush drain
        {4'd10, 9'b100100000, 10'b1000100000},  // R10 clears error
        {4'd8,  9'b000000001, 10'b0110000100},  // R8 discard
        {4'd12, 9'b110100000, 10'b1000100000},  // R12 direct start
        {4'd12, 9'b010000000, 10'b1000000000},  // R12 pause ignored
        {4'd12, 9'b000000010, 10'b0100000000},  // R12 finishes
        {4'd2,  9'b100000000, 10'b1000011000},  // R2
        {4'd6,  9'b011000000, 10'b0110000101},  // R6 pause+abort in fetch
        {4'd7,  9'b100000000, 10'b1000011000},  // R7 fresh after abort
        {4'd2,  9'b000001000, 10'b1000100000},  // R2
        {4'd3,  9'b010000000, 10'b1000000000},  // R3
        {4'd3,  9'b000000010, 10'b0001000000},  // R3
        {4'd6,  9'b101000000, 10'b0110000101},  // R6 go+abort while paused
        {4'd7,  9'b100000000, 10'b1000011000},  // R7 first fetch again
        {4'd2,  9'b000001100, 10'b1000100000},  // R2
        {4'd8,  9'b000000011, 10'b0110000100},  // R8 error beats done
        {4'd1,  9'b100100000, 10'b1000100000},  // R1
        {4'd5,  9'b001000000, 10'b0110000101}   // R5 abort direct transfer
    };

    function automatic logic [9:0] outs();
        return {busy, done, err, paused, xfer_start, desc_fetch, desc_first,
                fifo_inval, fifo_drain, eng_halt};
    endfunction

    task automatic check(input string tag, input logic [9:0] exp);
        n_checks++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, outs(), exp);
        end
    endtask

    task automatic drive(input logic [8:0] v);
        {cmd_go, cmd_pause, cmd_abort, mode_direct, flush_en,
         desc_done, desc_last, xfer_done, xfer_err} = v;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check("R11 reset state", 10'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk) drive(VEC[i][18:10]);
            @(posedge clk);
            #2;
            check($sformatf("R%0d row %0d", VEC[i][22:19], i), VEC[i][9:0]);
        end

        // R11: reset in the middle of a chained run
        @(negedge clk) drive(9'b100000000);
        @(negedge clk) drive(9'b000001000);
        @(negedge clk) begin drive(9'b0); rst = 1'b1; end
        @(posedge clk);
        #2 check("R11 reset mid-run", 10'b0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk);
        #2 check("R11 idle after reset", 10'b0);

        // R1: direct start right after reset
        @(negedge clk) drive(9'b100100000);
        @(posedge clk);
        #2 check("R1 start after reset", 10'b1000100000);
        @(negedge clk) drive(9'b000100000);
        @(posedge clk);
        #2 check("R1 single pulse", 10'b1000000000);
        @(negedge clk) drive(9'b0);
        finish_run();
    end

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                n_checks++;
                n_fail++;
                $display("FAIL watchdog: got %0d cycles expected under 5000", cycles);
                finish_run();
            end
        end
    end

endmodule